// File: doc/BRIEF.md
# On-Screen Display Position Timing Generator

This block tells the character engine of an on-screen display where each of its sixteen character blocks begins. It watches the video line and field sync signals, which reach it unsynchronised from outside, counts lines from the start of each field, and raises one output per block during the line where that block starts. Along each line it counts display dots from the line sync and raises one shared horizontal start strobe at a programmed position.

Software sets a 10-bit start line for each block and one 8-bit horizontal start for all blocks through a simple byte write port. Each start line is written as two bytes, a low byte and a high pair of bits. The pair only takes effect at the next field sync, so a frame that is already being shown never uses a half-written position. The horizontal position counts in steps of four display dots. A separate dot enable sets the dot rate inside the machine-cycle clock domain.

Top module: `osdpos_timing`

## Requirements
- R1: Bit 0 of `sync_neg` selects the line sync polarity and bit 1 selects the field sync polarity. When a bit is 0 the rising pin edge is the active edge, and when it is 1 the falling pin edge is the active edge. Each bit acts on its own input only.
- R2: An active field sync edge sets the line count to 0. After that, each counted active line sync edge adds one to the count.
- R3: A line sync edge that reaches its pin in the same cycle as the field sync edge, or one cycle later, is not counted. A line sync edge that arrives two or more cycles later is counted.
- R4: The line count stops at 1023. One more counted edge after that ends all vertical matches until the next field sync.
- R5: A write with `wr_addr` = n (0 to 15) sets the low 8 bits of block n's start line. A write with `wr_addr` = 16+n sets the top 2 bits from `wr_data[1:0]`. Neither write changes the outputs before the next active field sync edge, which copies both parts into use.
- R6: A block whose start line in use is 0 or 1 never raises its vertical start output.
- R7: `vstart[n]` is high exactly while the line count equals block n's start line in use. It changes on the third rising clock edge after the line sync pin transition.
- R8: `hstart` is high while the number of `dot_ce` cycles since the last active line sync edge equals four times the horizontal position. With `dot_ce` held high, it rises on rising clock edge 2+4H after the pin transition, counting the first edge as 0, and it lasts one cycle. With `dot_ce` low the dot count holds.
- R9: A write to `wr_addr` = 32 sets the horizontal position to `wr_data` and takes effect at once. Other addresses from 33 up are ignored.
- R10: While and after `rst` (synchronous, active high), all start lines in use and the horizontal position are 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_neg | input | 2 | Polarity select: bit 0 line sync, bit 1 field sync; 1 = falling edge active |
| hsync_pin | input | 1 | Raw line sync |
| vsync_pin | input | 1 | Raw field sync |
| dot_ce | input | 1 | One pulse per display dot |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register select |
| wr_data | input | 8 | Write data |
| vstart | output | 16 | Per-block vertical start, high for one line |
| hstart | output | 1 | Horizontal start strobe |

## Verification
The bench sweeps a full field of more than 1023 lines against a spread of start values, including 0, 1, 2, 255, 256, 1022, 1023 and a duplicate pair. This catches a design that matches disabled values, wraps the line counter (block 2 would fire again), or splits the start value at the wrong bit. It moves the line sync edge zero to three cycles after the field edge, which exposes a missing or too-wide guard window as a line offset of one. A mid-field rewrite exposes positions that take effect at write time. It sweeps the horizontal position across its range and measures the exact strobe cycle, which catches a lost step scale of four or an extra pipeline stage. It repeats the runs with inverted and mixed polarities.

// File: rtl/osdpos_pkg.sv
package osdpos_pkg;

    localparam int NBLK    = 16;               // character blocks
    localparam int VW      = 10;               // vertical start width
    localparam int HW      = 8;                // horizontal start width
    localparam int DW      = 8;                // write data width
    localparam int BW      = $clog2(NBLK);     // block index width
    localparam int AW      = BW + 2;           // write address width
    localparam int HSTEP_W = 2;                // log2 of dots per horizontal step
    localparam int DOTW    = HW + HSTEP_W;     // dot counter width
    localparam int VHI_W   = VW - DW;          // high part of vertical start
    localparam int SYNC_STAGES = 2;

    localparam logic [VW-1:0] VMIN_USABLE = VW'(2);

    typedef enum logic [1:0] {
        WR_NONE = 2'd0,
        WR_VLO  = 2'd1,
        WR_VHI  = 2'd2,
        WR_HPOS = 2'd3
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e        kind;
        logic [BW-1:0]   blk;
        logic [DW-1:0]   data;
    } wr_cmd_t;

    // Address map: 0..NBLK-1 low bytes, NBLK..2*NBLK-1 high bits,
    // 2*NBLK horizontal position, anything above ignored.
    function automatic wr_cmd_t decode_wr(input logic en,
                                          input logic [AW-1:0] addr,
                                          input logic [DW-1:0] data);
        wr_cmd_t c;
        c.blk  = addr[BW-1:0];
        c.data = data;
        c.kind = WR_NONE;
        if (en) begin
            if (addr[AW-1]) begin
                if (addr[AW-2:0] == '0)
                    c.kind = WR_HPOS;
            end else if (addr[AW-2]) begin
                c.kind = WR_VHI;
            end else begin
                c.kind = WR_VLO;
            end
        end
        return c;
    endfunction

    function automatic logic start_usable(input logic [VW-1:0] v);
        return v >= VMIN_USABLE;
    endfunction

endpackage

// File: rtl/osdpos_sync_edge.sv
module osdpos_sync_edge
    import osdpos_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic neg,
    output logic evt
);

    logic [STAGES-1:0] sync_q;
    logic              lvl;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {STAGES{neg}};
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= lvl;
        end
    end

    assign lvl = sync_q[STAGES-1] ^ neg;
    assign evt = lvl & ~prev_q;

    // R1: an active edge is a single-cycle event
    a_r1_edge_single: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

endmodule

// File: rtl/osdpos_line_track.sv
module osdpos_line_track
    import osdpos_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hs_evt,
    input  logic          vs_evt,
    output logic [VW-1:0] line_cnt,
    output logic          line_ovf
);

    localparam logic [VW-1:0] LMAX = '1;

    logic guard_q;
    logic count_ok;

    assign count_ok = hs_evt && !vs_evt && !guard_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt <= '0;
            line_ovf <= 1'b0;
            guard_q  <= 1'b0;
        end else begin
            guard_q <= vs_evt;
            if (vs_evt) begin
                line_cnt <= '0;
                line_ovf <= 1'b0;
            end else if (count_ok) begin
                if (line_cnt == LMAX)
                    line_ovf <= 1'b1;
                else
                    line_cnt <= line_cnt + VW'(1);
            end
        end
    end

    // R2: field reference restarts the count
    a_r2_field_restart: assert property (@(posedge clk) disable iff (rst)
        vs_evt |=> (line_cnt == '0) && !line_ovf);

    // R3: a line edge inside the guard cycle leaves the count alone
    a_r3_guard_hold: assert property (@(posedge clk) disable iff (rst)
        (guard_q && !vs_evt) |=> $stable(line_cnt));

    // R4: count never wraps past its maximum
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (line_cnt == LMAX && !vs_evt) |=> line_cnt == LMAX);

endmodule

// File: rtl/osdpos_vpos_bank.sv
module osdpos_vpos_bank
    import osdpos_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_cmd_t         cmd,
    input  logic            vs_evt,
    input  logic [VW-1:0]   line_cnt,
    input  logic            line_ovf,
    output logic [NBLK-1:0] vstart
);

    logic [NBLK-1:0][DW-1:0]    lo_q;
    logic [NBLK-1:0][VHI_W-1:0] hi_q;
    logic [NBLK-1:0][VW-1:0]    act_q;

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[g]  <= '0;
                hi_q[g]  <= '0;
                act_q[g] <= '0;
            end else begin
                if (cmd.kind == WR_VLO && cmd.blk == BW'(g))
                    lo_q[g] <= cmd.data;
                if (cmd.kind == WR_VHI && cmd.blk == BW'(g))
                    hi_q[g] <= cmd.data[VHI_W-1:0];
                if (vs_evt)
                    act_q[g] <= {hi_q[g], lo_q[g]};
            end
        end

        assign vstart[g] = !line_ovf && start_usable(act_q[g])
                           && (line_cnt == act_q[g]);

        // R6: a start of 0 or 1 never produces a strobe
        a_r6_low_quiet: assert property (@(posedge clk) disable iff (rst)
            (act_q[g] < VMIN_USABLE) |-> !vstart[g]);
    end

    // R5: positions in use change only at the field reference
    a_r5_field_load: assert property (@(posedge clk) disable iff (rst)
        !vs_evt |=> $stable(act_q));

endmodule

// File: rtl/osdpos_hpos_gen.sv
module osdpos_hpos_gen
    import osdpos_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hs_evt,
    input  logic          dot_ce,
    input  logic          hpos_we,
    input  logic [DW-1:0] hpos_data,
    output logic          hstart
);

    logic [HW-1:0]   hpos_q;
    logic [DOTW-1:0] dot_q;
    logic [DOTW-1:0] target;

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos_q <= '0;
            dot_q  <= '1;
        end else begin
            if (hpos_we)
                hpos_q <= hpos_data[HW-1:0];
            if (hs_evt)
                dot_q <= '0;
            else if (dot_ce && dot_q != '1)
                dot_q <= dot_q + DOTW'(1);
        end
    end

    assign target = {hpos_q, {HSTEP_W{1'b0}}};
    assign hstart = (dot_q == target);

    // R8: with the dot enable running the strobe lasts one dot
    a_r8_single_dot: assert property (@(posedge clk) disable iff (rst)
        (hstart && dot_ce && !hs_evt && !hpos_we) |=> !hstart);

    // R8: a held dot enable freezes the dot count
    a_r8_dot_hold: assert property (@(posedge clk) disable iff (rst)
        (!dot_ce && !hs_evt) |=> $stable(dot_q));

endmodule

// File: rtl/osdpos_timing.sv
module osdpos_timing
    import osdpos_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      sync_neg,
    input  logic            hsync_pin,
    input  logic            vsync_pin,
    input  logic            dot_ce,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [NBLK-1:0] vstart,
    output logic            hstart
);

    logic          hs_evt;
    logic          vs_evt;
    logic [VW-1:0] line_cnt;
    logic          line_ovf;
    wr_cmd_t       cmd;

    assign cmd = decode_wr(wr_en, wr_addr, wr_data);

    osdpos_sync_edge #(.STAGES(SYNC_STAGES)) i_hs_edge (
        .clk (clk), .rst (rst), .pin (hsync_pin), .neg (sync_neg[0]),
        .evt (hs_evt)
    );

    osdpos_sync_edge #(.STAGES(SYNC_STAGES)) i_vs_edge (
        .clk (clk), .rst (rst), .pin (vsync_pin), .neg (sync_neg[1]),
        .evt (vs_evt)
    );

    osdpos_line_track i_lines (
        .clk (clk), .rst (rst), .hs_evt (hs_evt), .vs_evt (vs_evt),
        .line_cnt (line_cnt), .line_ovf (line_ovf)
    );

    osdpos_vpos_bank i_vbank (
        .clk (clk), .rst (rst), .cmd (cmd), .vs_evt (vs_evt),
        .line_cnt (line_cnt), .line_ovf (line_ovf), .vstart (vstart)
    );

    osdpos_hpos_gen i_hgen (
        .clk (clk), .rst (rst), .hs_evt (hs_evt), .dot_ce (dot_ce),
        .hpos_we (cmd.kind == WR_HPOS), .hpos_data (cmd.data),
        .hstart (hstart)
    );

    // R10: outputs are quiet in the cycle after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (vstart == '0) && !hstart);

endmodule

// File: tb/test_osdpos_timing.sv
module test_osdpos_timing;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sync_neg = 2'b00;
    logic        hsync_pin = 1'b0;
    logic        vsync_pin = 1'b0;
    logic        dot_ce = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] vstart;
    logic        hstart;

    int n_vec = 0;
    int n_err = 0;
    int cyc = 0;

    int sh[16];
    int act[16];
    int line_n;
    bit line_ov;

    always #10 clk = ~clk;

    osdpos_timing i_osdpos_timing (
        .clk (clk), .rst (rst), .sync_neg (sync_neg),
        .hsync_pin (hsync_pin), .vsync_pin (vsync_pin), .dot_ce (dot_ce),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .vstart (vstart), .hstart (hstart)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 190000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    task automatic check(input string req, input int act_v, input int exp_v);
        n_vec++;
        if (act_v != exp_v) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    function automatic logic [15:0] exp_vec();
        logic [15:0] v = '0;
        for (int i = 0; i < 16; i++)
            v[i] = !line_ov && act[i] >= 2 && line_n == act[i];
        return v;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(input int i, input int v);
        wr(i, v & 255);
        wr(16 + i, (v >> 8) & 3);
        sh[i] = v;
    endtask

    task automatic do_reset(input logic [1:0] pol);
        @(negedge clk);
        rst = 1'b1; sync_neg = pol;
        hsync_pin = pol[0]; vsync_pin = pol[1];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin sh[i] = 0; act[i] = 0; end
        line_n = 0; line_ov = 0;
        repeat (3) @(negedge clk);
        check("R10 vstart after reset", int'(vstart), 0);
        check("R10 hstart after reset", int'(hstart), 0);
    endtask

    task automatic line_pulse(input string req);
        hsync_pin = ~sync_neg[0];
        repeat (8) @(negedge clk);
        hsync_pin = sync_neg[0];
        repeat (8) @(negedge clk);
        if (line_n == 1023) line_ov = 1; else line_n++;
        check(req, int'(vstart), int'(exp_vec()));
    endtask

    task automatic field_start();
        vsync_pin = ~sync_neg[1];
        repeat (10) @(negedge clk);
        vsync_pin = sync_neg[1];
        repeat (2) @(negedge clk);
        for (int i = 0; i < 16; i++) act[i] = sh[i];
        line_n = 0; line_ov = 0;
        check("R2 vstart at field start", int'(vstart), 0);
    endtask

    task automatic guard_field(input int d);
        vsync_pin = ~sync_neg[1];
        repeat (d) @(negedge clk);
        hsync_pin = ~sync_neg[0];
        repeat (10) @(negedge clk);
        vsync_pin = sync_neg[1];
        hsync_pin = sync_neg[0];
        repeat (8) @(negedge clk);
        for (int i = 0; i < 16; i++) act[i] = sh[i];
        line_ov = 0;
        line_n = (d >= 2) ? 1 : 0;
        check($sformatf("R3 guard offset %0d first line", d), int'(vstart), int'(exp_vec()));
        for (int k = 0; k < 3; k++)
            line_pulse($sformatf("R3 guard offset %0d later line", d));
    endtask

    task automatic hmeasure(input int h, input string req);
        int first;
        int width;
        wr(32, h);
        @(negedge clk);
        hsync_pin = ~sync_neg[0];
        first = -1; width = 0;
        for (int k = 0; k < 1100; k++) begin
            @(negedge clk);
            if (hstart) begin
                if (first < 0) first = k;
                width++;
            end
            if (k == 8) hsync_pin = sync_neg[0];
        end
        check($sformatf("%s position H=%0d", req, h), first, 2 + 4 * h);
        check($sformatf("%s width H=%0d", req, h), width, 1);
    endtask

    task automatic program_set();
        int vals[16] = '{0, 1, 2, 3, 255, 256, 511, 512,
                         700, 1022, 1023, 2, 257, 769, 100, 1000};
        for (int i = 0; i < 16; i++) prog(i, vals[i]);
    endtask

    initial begin
        do_reset(2'b00);

        // R5: written values are not used before a field edge
        program_set();
        for (int k = 0; k < 3; k++) line_pulse("R5 no effect before field edge");

        // R2 R4 R6 R7: full field beyond saturation
        field_start();
        for (int k = 0; k < 1030; k++) line_pulse("R7 R4 R6 full field sweep");

        // R5: mid-field rewrite keeps old values until next field
        field_start();
        for (int k = 0; k < 10; k++) line_pulse("R7 field two");
        prog(14, 60);
        prog(3, 40);
        for (int k = 0; k < 110; k++) line_pulse("R5 old value held in field");
        field_start();
        for (int k = 0; k < 120; k++) line_pulse("R5 new value after field edge");

        // R3: guard window around field reference
        prog(0, 2);
        prog(1, 3);
        for (int d = 0; d < 4; d++) guard_field(d);

        // R8 R9: horizontal position sweep
        begin
            int hv[8] = '{0, 1, 2, 7, 63, 128, 200, 255};
            for (int j = 0; j < 8; j++) hmeasure(hv[j], "R8 R9 hstart");
        end

        // R8: dot enable held low freezes the dot count
        wr(32, 5);
        dot_ce = 1'b0;
        @(negedge clk);
        hsync_pin = ~sync_neg[0];
        begin
            int seen = 0;
            for (int k = 0; k < 100; k++) begin
                @(negedge clk);
                if (hstart) seen++;
                if (k == 8) hsync_pin = sync_neg[0];
            end
            check("R8 no strobe with dot_ce low", seen, 0);
        end
        dot_ce = 1'b1;

        // R9: address above the map is ignored
        wr(40, 9);
        hmeasure(5, "R9 ignored address keeps H");

        // R1: both polarities inverted
        do_reset(2'b11);
        program_set();
        field_start();
        for (int k = 0; k < 1030; k++) line_pulse("R1 inverted polarity field");
        hmeasure(3, "R1 inverted hstart");
        guard_field(1);
        guard_field(2);

        // R1: mixed polarity
        do_reset(2'b01);
        program_set();
        field_start();
        for (int k = 0; k < 20; k++) line_pulse("R1 mixed polarity 01");
        do_reset(2'b10);
        program_set();
        field_start();
        for (int k = 0; k < 20; k++) line_pulse("R1 mixed polarity 10");
        hmeasure(10, "R1 mixed hstart");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule